// File: doc/BRIEF.md
# SPI Serial Byte Memory with Wrapping Burst Access

This block is an SPI slave that behaves like a small byte-addressed serial memory. A master selects it by pulling chip-select low, sends a one-byte command, and for data access follows the command with a 16-bit address and as many data bytes as it likes. The internal address advances once per data byte and rolls over from the last location of the array to location zero. The burst is never cut short by the slave. It lasts until the master releases chip-select.

Stored data lives in a flop-based RAM of `2**DEPTH_LOG2` bytes. Writes are guarded by a write-enable latch that software sets and clears with dedicated commands. The latch also drops by itself when a write transaction closes. A status command reports the latch. All pins are sampled on a free-running system clock through a synchronizer, so the serial clock must be several times slower than `clk`. The bench keeps a serial clock half-period of six system clocks.

Top module: `snvm_spi_mem`

## Requirements
- R1: Releasing chip-select (high) at any point ends the transaction, and the next chip-select assertion starts again with a fresh command byte.
- R2: Command 0x03 followed by an address high byte and then an address low byte returns the array byte at that address. Its MSB is driven on the first serial-clock falling edge after the last address bit, with no dummy cycles.
- R3: During a burst the address rises by one per data byte and wraps from `2**DEPTH_LOG2-1` to 0. Address bits at or above `DEPTH_LOG2` are ignored.
- R4: Command 0x02 with address bytes stores every following data byte at successive addresses while the write-enable latch is set. The number of bytes is unlimited and the address wraps as in R3.
- R5: Data bytes of a 0x02 transaction leave the array unchanged while the write-enable latch is clear.
- R6: The write-enable latch is clear after reset. Command 0x06 sets it and 0x04 clears it. It clears when chip-select rises at the end of any transaction whose command was 0x02.
- R7: Command 0x05 returns a status byte with the write-enable latch in bit 1 and all other bits 0. The byte repeats for as long as chip-select stays low.
- R8: Serial mode 0 is used. MOSI is sampled on serial-clock rising edges and MISO changes only after falling edges, MSB first. MISO is 0 while chip-select is high and during the command and address bytes.
- R9: A byte cut short by chip-select rising is discarded. A partial data byte is not stored, and a partial command has no effect.
- R10: Any other command value makes the slave ignore the rest of the transaction. MISO stays 0, the array is untouched and the latch is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
A pin change reaches the decoder about three system clocks after it happens. It passes two synchronizer stages and then the edge-detect register. MISO is registered one clock later, so a new output bit is settled at most about four clocks after a serial-clock falling edge. The bench drives every serial-clock phase for six clocks and reads MISO just before each rising edge, which gives the output two clocks of margin. It also waits several half-periods after a chip-select change. Effects on the array and on the write-enable latch are not sampled in the cycle they happen. They are checked later through read and status transactions.

// File: rtl/snvm_pkg.sv
package snvm_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_READ       = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRITE      = 8'h02;
    localparam logic [BYTE_W-1:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_DISABLE = 8'h04;
    localparam logic [BYTE_W-1:0] OP_STATUS     = 8'h05;

    localparam int LATCH_BIT = 1;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_RDATA,
        PH_WDATA,
        PH_STATUS,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic latch);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[LATCH_BIT] = latch;
        return s;
    endfunction

    function automatic phase_e phase_after_cmd(input logic [BYTE_W-1:0] op);
        phase_e p;
        case (op)
            OP_READ, OP_WRITE: p = PH_ADDR_HI;
            OP_STATUS:         p = PH_STATUS;
            default:           p = PH_DROP;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/snvm_pin_sync.sv
module snvm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic mosi_bit
);
    localparam logic [2:0] PIN_RESET = 3'b010;  // {sclk, cs_n, mosi}

    logic [2:0] stage_q [STAGES];
    logic [2:0] pins_s;
    logic       sclk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PIN_RESET;
            sclk_last <= 1'b0;
        end else begin
            stage_q[0] <= {sclk_pin, cs_n_pin, mosi_pin};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            sclk_last <= pins_s[2];
        end
    end

    assign pins_s    = stage_q[STAGES-1];
    assign sclk_rise = pins_s[2] & ~sclk_last;
    assign sclk_fall = ~pins_s[2] & sclk_last;
    assign sel       = ~pins_s[1];
    assign mosi_bit  = pins_s[0];
endmodule

// File: rtl/snvm_rx.sv
module snvm_rx
    import snvm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel,
    input  logic     sclk_rise,
    input  logic     mosi_bit,
    output rx_byte_t rx
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (sclk_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shift_q <= {shift_q[BYTE_W-3:0], mosi_bit};
        end
    end

    always_comb begin
        rx.valid = sel && sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
        rx.data  = {shift_q, mosi_bit};
    end
endmodule

// File: rtl/snvm_ctrl.sv
module snvm_ctrl
    import snvm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sclk_fall,
    input  rx_byte_t          rx,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              miso,
    output phase_e            phase,
    output logic [AW-1:0]     cur_addr,
    output logic              wel,
    output logic              wr_txn
);
    logic [BYTE_W-1:0]   addr_hi;
    logic [2*BYTE_W-1:0] full_addr;
    logic                is_read;
    logic [BYTE_W-1:0]   tx_q;
    logic                miso_q;
    logic                unused_addr_bits;

    assign full_addr        = {addr_hi, rx.data};
    assign unused_addr_bits = ^full_addr;

    always_comb begin
        rd_addr = (phase == PH_ADDR_LO) ? full_addr[AW-1:0] : cur_addr + 1'b1;
        wr_en   = rx.valid && (phase == PH_WDATA) && wel;
        wr_addr = cur_addr;
        wr_data = rx.data;
        miso    = miso_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            addr_hi  <= '0;
            cur_addr <= '0;
            is_read  <= 1'b0;
            wel      <= 1'b0;
            wr_txn   <= 1'b0;
            tx_q     <= '0;
            miso_q   <= 1'b0;
        end else if (!sel) begin
            phase  <= PH_CMD;
            tx_q   <= '0;
            miso_q <= 1'b0;
            wr_txn <= 1'b0;
            if (wr_txn) wel <= 1'b0;
        end else begin
            if (sclk_fall) begin
                miso_q <= tx_q[BYTE_W-1];
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
            end
            if (rx.valid) begin
                case (phase)
                    PH_CMD: begin
                        phase   <= phase_after_cmd(rx.data);
                        is_read <= (rx.data == OP_READ);
                        if (rx.data == OP_WR_ENABLE)  wel    <= 1'b1;
                        if (rx.data == OP_WR_DISABLE) wel    <= 1'b0;
                        if (rx.data == OP_WRITE)      wr_txn <= 1'b1;
                        if (rx.data == OP_STATUS)     tx_q   <= status_byte(wel);
                    end
                    PH_ADDR_HI: begin
                        addr_hi <= rx.data;
                        phase   <= PH_ADDR_LO;
                    end
                    PH_ADDR_LO: begin
                        cur_addr <= rd_addr;
                        phase    <= is_read ? PH_RDATA : PH_WDATA;
                        if (is_read) tx_q <= rd_data;
                    end
                    PH_RDATA: begin
                        cur_addr <= rd_addr;
                        tx_q     <= rd_data;
                    end
                    PH_WDATA:  cur_addr <= cur_addr + 1'b1;
                    PH_STATUS: tx_q     <= status_byte(wel);
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/snvm_array.sv
module snvm_array
    import snvm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/snvm_spi_mem.sv
module snvm_spi_mem
    import snvm_pkg::*;
#(
    parameter int DEPTH_LOG2  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW = DEPTH_LOG2;

    logic              sclk_rise, sclk_fall, sel, mosi_bit;
    rx_byte_t          rx_byte;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [AW-1:0]     rd_addr, wr_addr, cur_addr;
    logic              wr_en, wel, wr_txn;
    phase_e            phase;

    snvm_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst),
        .sclk_pin(spi_sclk), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sel(sel), .mosi_bit(mosi_bit)
    );

    snvm_rx rx_i (
        .clk(clk), .rst(rst), .sel(sel), .sclk_rise(sclk_rise),
        .mosi_bit(mosi_bit), .rx(rx_byte)
    );

    snvm_ctrl #(.AW(AW)) ctrl_i (
        .clk(clk), .rst(rst), .sel(sel), .sclk_fall(sclk_fall), .rx(rx_byte),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(spi_miso), .phase(phase), .cur_addr(cur_addr),
        .wel(wel), .wr_txn(wr_txn)
    );

    snvm_array #(.AW(AW)) array_i (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/snvm_spi_mem_chk.sv
module snvm_spi_mem_chk
    import snvm_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          sclk_fall,
    input logic          rx_valid,
    input phase_e        phase,
    input logic [AW-1:0] addr,
    input logic          wel,
    input logic          wr_txn,
    input logic          wr_en,
    input logic          miso
);
    assert_frame_restart_R1: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (phase == PH_CMD));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && (phase == PH_RDATA || phase == PH_WDATA)) |=> (addr == $past(addr) + 1'b1));

    assert_write_guard_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wel);

    assert_latch_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (!sel && wr_txn) |=> !wel);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !miso);

    assert_miso_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (sel && !sclk_fall) |=> $stable(miso));

    assert_drop_inert_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DROP) |-> !wr_en);
endmodule

bind snvm_spi_mem snvm_spi_mem_chk #(.AW(DEPTH_LOG2)) chk_i (
    .clk(clk), .rst(rst), .sel(sel), .sclk_fall(sclk_fall),
    .rx_valid(rx_byte.valid), .phase(phase), .addr(cur_addr),
    .wel(wel), .wr_txn(wr_txn), .wr_en(wr_en), .miso(spi_miso)
);

// File: tb/snvm_spi_mem_tb_top.sv
`timescale 1ns/1ps
module snvm_spi_mem_tb_top;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int HP    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [DEPTH];
    bit model_wel = 1'b0;

    always #2.5 clk = ~clk;

    snvm_spi_mem #(.DEPTH_LOG2(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb, input int nbits = 8);
        rxb = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HP);
            rxb[i] = miso;
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_open();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_close();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic one_cmd(input logic [7:0] op);
        logic [7:0] r;
        cs_open();
        xfer(op, r);
        cs_close();
        if (op == 8'h06) model_wel = 1'b1;
        if (op == 8'h04) model_wel = 1'b0;
    endtask

    function automatic logic [7:0] exp_status();
        return {6'b0, model_wel, 1'b0};
    endfunction

    task automatic status_check(input string req);
        logic [7:0] r0, r1, d;
        cs_open();
        xfer(8'h05, d);
        xfer(8'h00, r0);
        xfer(8'h00, r1);
        cs_close();
        check8(req, "status byte", r0, exp_status());
        check8("R7", "status repeat", r1, exp_status());
    endtask

    task automatic write_burst(input logic [15:0] base, input int n);
        logic [7:0] r, b;
        cs_open();
        xfer(8'h02, r);
        xfer(base[15:8], r);
        xfer(base[7:0], r);
        for (int k = 0; k < n; k++) begin
            b = 8'($urandom_range(0, 255));
            xfer(b, r);
            if (model_wel) model[(int'(base) + k) % DEPTH] = b;
        end
        cs_close();
        model_wel = 1'b0;
    endtask

    task automatic read_burst(input string req, input logic [15:0] base, input int n);
        logic [7:0] r;
        cs_open();
        xfer(8'h03, r);     check8("R8", "miso during command", r, 8'h00);
        xfer(base[15:8], r); check8("R8", "miso during addr hi", r, 8'h00);
        xfer(base[7:0], r);  check8("R8", "miso during addr lo", r, 8'h00);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            check8(req, $sformatf("read byte %0d", k), r, model[(int'(base) + k) % DEPTH]);
        end
        cs_close();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_0042));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        check8("R8", "miso after reset", {7'b0, miso}, 8'h00);
        status_check("R6");

        one_cmd(8'h06);
        status_check("R6");
        one_cmd(8'h04);
        status_check("R6");

        one_cmd(8'h06);
        write_burst(16'h0000, DEPTH);
        status_check("R6");
        read_burst("R4", 16'h0000, 8);

        read_burst("R3", 16'h37F0, 40);
        read_burst("R2", 16'h0081, 1);

        write_burst(16'h0005, 3);
        read_burst("R5", 16'h0005, 3);

        one_cmd(8'h06);
        write_burst(16'h00FE, 4);
        read_burst("R4", 16'h00FE, 4);

        one_cmd(8'h06);
        cs_open();
        xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r);
        xfer(8'hC3, r);
        xfer(8'h5A, r, 5);
        cs_close();
        model[16'h10] = 8'hC3;
        model_wel = 1'b0;
        read_burst("R9", 16'h0010, 2);

        cs_open();
        xfer(8'h06, r, 7);
        cs_close();
        status_check("R9");
        read_burst("R1", 16'h0042, 2);

        one_cmd(8'h06);
        cs_open();
        xfer(8'hAB, r);
        xfer(8'h02, r); check8("R10", "miso after bad op", r, 8'h00);
        xfer(8'h00, r); check8("R10", "miso after bad op", r, 8'h00);
        xfer(8'h20, r);
        xfer(8'h99, r); check8("R10", "miso after bad op", r, 8'h00);
        cs_close();
        status_check("R10");
        read_burst("R10", 16'h0020, 1);
        one_cmd(8'h04);

        for (int it = 0; it < 12; it++) begin
            logic [15:0] a;
            int len;
            a   = 16'($urandom_range(0, 65535));
            len = $urandom_range(1, 8);
            if ($urandom_range(0, 1) == 1) one_cmd(8'h06);
            write_burst(a, len);
            status_check("R6");
            read_burst(model_wel ? "R4" : "R4", a, len);
        end

        check8("R8", "miso idle at end", {7'b0, miso}, 8'h00);
        check8("R1", "cs released at end", {7'b0, cs_n}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule